// File: doc/BRIEF.md
# Page Write Buffer With Commit

This block collects the data bytes of one write frame into a small page buffer and, when the frame closes at a legal point, copies the loaded bytes into a byte-wide storage array during a self-timed write cycle. A write frame opens with a start address. Each byte that follows goes to the next offset inside the same page. The offset wraps from the top of the page back to its base, so a frame longer than one page overwrites the bytes it loaded earlier.

The frame closes when chip select is released. The buffer is committed only when that release lands on a byte boundary, at least one data byte has been loaded, the write-enable latch is set and the write-protect input is high. Any other release drops the buffered data. A commit raises a busy flag for a fixed number of clock cycles. During that time the loaded bytes are written to the array, array reads are blocked, and new frames are ignored. In the final busy cycle the block pulses a request that clears the write-enable latch.

Top module: `page_write_commit`

## Requirements
- R1: While reset is asserted and immediately after it is released, write_busy, array_rd_block, latch_clr and arr_we are all 0.
- R2: The first byte of a committed frame goes to the start address. Each later byte goes to the next offset, and the low PAGE_W address bits (4 by default) wrap from 15 to 0 while the upper bits stay fixed. When a frame carries more than 16 bytes, the last byte loaded to an offset is the value that reaches the array.
- R3: A commit needs sel_release and bit_boundary high in the same cycle, with a frame open and at least one data byte loaded. A release with bit_boundary low, or one with no data byte, leaves write_busy low and the array unchanged.
- R4: A release with wr_en_latch low or wr_protect_n low starts no write cycle and leaves the array unchanged.
- R5: write_busy rises on the clock edge that samples a commit and stays high for exactly WR_CYCLES consecutive cycles.
- R6: array_rd_block is high in exactly the cycles in which write_busy is high.
- R7: latch_clr is high for exactly one cycle per write cycle, in the last cycle in which write_busy is high, and is never high at any other time.
- R8: arr_we is high only while write_busy is high. Array locations that the committed frame did not load keep their previous contents.
- R9: frame_start, byte_valid and sel_release are ignored while write_busy is high. A frame attempted during a write cycle changes no array location and starts no later cycle.
- R10: A byte presented with byte_valid in the same cycle as a committing sel_release is included in the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Opens a write frame at start_addr |
| start_addr | input | ADDR_W | First array address of the frame |
| byte_valid | input | 1 | One data byte is present on byte_data |
| byte_data | input | DATA_W | Data byte |
| bit_boundary | input | 1 | The serial bit count sits on a byte boundary |
| sel_release | input | 1 | Chip select has just risen |
| wr_en_latch | input | 1 | Current state of the write-enable latch |
| wr_protect_n | input | 1 | Low blocks writes to the array |
| write_busy | output | 1 | Write cycle in progress |
| array_rd_block | output | 1 | Array reads must be refused |
| latch_clr | output | 1 | Request to clear the write-enable latch |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
Two pairs of events can fall in the same cycle. The final data byte can arrive on the cycle that chip select is released. A new frame, with its bytes and its release, can also arrive while a write cycle is still running. The bench sends both on purpose: the final byte is placed on the release cycle, and a whole legal-looking frame is sent a few cycles after busy rises. The first case passes when the byte is found in the array. The second passes when the array is unchanged and no second busy period follows. Random frames also vary the byte count past the page size, the release point and the permission inputs. After each frame, a bench model of the array is compared in full with the expected contents.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic {
    FR_IDLE = 1'b0,
    FR_LOAD = 1'b1
  } frame_state_e;
endpackage

// File: rtl/pwc_page_buf.sv
module pwc_page_buf #(
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_i,
  input  logic [PAGE_W-1:0]      start_off_i,
  input  logic                   ld_i,
  input  logic [DATA_W-1:0]      din_i,
  output logic [(1<<PAGE_W)-1:0] mask_o,
  output logic [(1<<PAGE_W)-1:0] mask_nxt_o,
  input  logic [PAGE_W-1:0]      rd_idx_i,
  output logic [DATA_W-1:0]      rd_data_o
);
  localparam int PAGE = 1 << PAGE_W;

  logic [PAGE_W-1:0] ptr_q, ptr_d;
  logic [PAGE-1:0]   mask_q, mask_d;
  logic [DATA_W-1:0] buf_q [PAGE];

  always_comb begin
    ptr_d  = ptr_q;
    mask_d = mask_q;
    if (clr_i) begin
      ptr_d  = start_off_i;
      mask_d = '0;
    end else if (ld_i) begin
      ptr_d  = ptr_q + 1'b1;
      mask_d = mask_q | (PAGE'(1) << ptr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      mask_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      mask_q <= mask_d;
    end
  end

  for (genvar g = 0; g < PAGE; g++) begin : g_entry
    logic en;
    assign en = ld_i && !clr_i && (ptr_q == PAGE_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf_q[g] <= '0;
      end else if (en) begin
        buf_q[g] <= din_i;
      end
    end
  end

  assign mask_o     = mask_q;
  assign mask_nxt_o = mask_d;
  assign rd_data_o  = buf_q[rd_idx_i];
endmodule

// File: rtl/pwc_cycle_timer.sv
module pwc_cycle_timer #(
  parameter int WR_CYCLES = 40,
  parameter int PAGE_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              last_o,
  output logic              scan_act_o,
  output logic [PAGE_W-1:0] scan_idx_o
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam int PAGE  = 1 << PAGE_W;

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PAGE_W:0]  scan_q, scan_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    scan_d = scan_q;
    if (start_i && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(WR_CYCLES - 1);
      scan_d = '0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      if (scan_q < (PAGE_W+1)'(PAGE)) begin
        scan_d = scan_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      scan_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      scan_q <= scan_d;
    end
  end

  assign busy_o     = busy_q;
  assign last_o     = busy_q && (cnt_q == '0);
  assign scan_act_o = busy_q && !scan_q[PAGE_W];
  assign scan_idx_o = scan_q[PAGE_W-1:0];
endmodule

// File: rtl/page_write_commit.sv
module page_write_commit #(
  parameter int ADDR_W    = 9,
  parameter int PAGE_W    = 4,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              bit_boundary,
  input  logic              sel_release,
  input  logic              wr_en_latch,
  input  logic              wr_protect_n,
  output logic              write_busy,
  output logic              array_rd_block,
  output logic              latch_clr,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);
  import pwc_pkg::*;

  localparam int PAGE   = 1 << PAGE_W;
  localparam int BASE_W = ADDR_W - PAGE_W;

  frame_state_e      fst_q, fst_d;
  logic [BASE_W-1:0] base_q;
  logic              base_en;
  logic              busy;
  logic              last;
  logic              scan_act;
  logic [PAGE_W-1:0] scan_idx;
  logic [PAGE-1:0]   mask, mask_nxt;
  logic [DATA_W-1:0] rd_data;
  logic              frame_ok;
  logic              load;
  logic              commit;

  assign frame_ok = frame_start && !busy;
  assign load     = byte_valid && (fst_q == FR_LOAD) && !frame_start && !busy;
  assign commit   = sel_release && (fst_q == FR_LOAD) && !busy && !frame_start
                    && bit_boundary && (|mask_nxt) && wr_en_latch && wr_protect_n;
  assign base_en  = frame_ok;

  always_comb begin
    fst_d = fst_q;
    if (frame_ok) begin
      fst_d = FR_LOAD;
    end else if (sel_release) begin
      fst_d = FR_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst_q <= FR_IDLE;
    end else begin
      fst_q <= fst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= start_addr[ADDR_W-1:PAGE_W];
    end
  end

  pwc_page_buf #(
    .PAGE_W (PAGE_W),
    .DATA_W (DATA_W)
  ) buf_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (frame_ok),
    .start_off_i (start_addr[PAGE_W-1:0]),
    .ld_i        (load),
    .din_i       (byte_data),
    .mask_o      (mask),
    .mask_nxt_o  (mask_nxt),
    .rd_idx_i    (scan_idx),
    .rd_data_o   (rd_data)
  );

  pwc_cycle_timer #(
    .WR_CYCLES (WR_CYCLES),
    .PAGE_W    (PAGE_W)
  ) tmr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (commit),
    .busy_o     (busy),
    .last_o     (last),
    .scan_act_o (scan_act),
    .scan_idx_o (scan_idx)
  );

  assign write_busy     = busy;
  assign array_rd_block = busy;
  assign latch_clr      = last;
  assign arr_we         = scan_act && mask[scan_idx];
  assign arr_addr       = {base_q, scan_idx};
  assign arr_wdata      = rd_data;
endmodule

// File: rtl/pwc_chk.sv
module pwc_chk #(
  parameter int WR_CYCLES = 40
) (
  input logic clk,
  input logic rst_n,
  input logic sel_release,
  input logic bit_boundary,
  input logic wr_en_latch,
  input logic wr_protect_n,
  input logic write_busy,
  input logic latch_clr,
  input logic arr_we
);
  localparam int CW = $clog2(WR_CYCLES + 2);

  logic [CW-1:0] wcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
    end else if (write_busy) begin
      wcnt_q <= wcnt_q + 1'b1;
    end else begin
      wcnt_q <= '0;
    end
  end

  // R3
  commit_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(write_busy) |-> $past(sel_release && bit_boundary));

  // R4
  commit_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(write_busy) |-> $past(wr_en_latch && wr_protect_n));

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(write_busy) |-> (wcnt_q == CW'(WR_CYCLES)));

  // R5
  busy_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    write_busy |-> (wcnt_q < CW'(WR_CYCLES)));

  // R7
  clr_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_clr |=> !write_busy);

  // R7
  clr_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_clr |-> write_busy);

  // R8
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> write_busy);
endmodule

bind page_write_commit pwc_chk #(.WR_CYCLES(WR_CYCLES)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel_release  (sel_release),
  .bit_boundary (bit_boundary),
  .wr_en_latch  (wr_en_latch),
  .wr_protect_n (wr_protect_n),
  .write_busy   (write_busy),
  .latch_clr    (latch_clr),
  .arr_we       (arr_we)
);

// File: tb/page_write_commit_tb.sv
module page_write_commit_tb_top;
  localparam int TCLK   = 10;
  localparam int WRC    = 24;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk;
  logic              rst_n;
  logic              frame_start;
  logic [ADDR_W-1:0] start_addr;
  logic              byte_valid;
  logic [DATA_W-1:0] byte_data;
  logic              bit_boundary;
  logic              sel_release;
  logic              wr_en_latch;
  logic              wr_protect_n;
  logic              write_busy;
  logic              array_rd_block;
  logic              latch_clr;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_addr;
  logic [DATA_W-1:0] arr_wdata;

  page_write_commit #(
    .ADDR_W    (ADDR_W),
    .PAGE_W    (4),
    .DATA_W    (DATA_W),
    .WR_CYCLES (WRC)
  ) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_start    (frame_start),
    .start_addr     (start_addr),
    .byte_valid     (byte_valid),
    .byte_data      (byte_data),
    .bit_boundary   (bit_boundary),
    .sel_release    (sel_release),
    .wr_en_latch    (wr_en_latch),
    .wr_protect_n   (wr_protect_n),
    .write_busy     (write_busy),
    .array_rd_block (array_rd_block),
    .latch_clr      (latch_clr),
    .arr_we         (arr_we),
    .arr_addr       (arr_addr),
    .arr_wdata      (arr_wdata)
  );

  logic [DATA_W-1:0] mem  [DEPTH];
  logic [DATA_W-1:0] expm [DEPTH];
  int runs  = 0;
  int fails = 0;
  int we_outside = 0;

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  always @(posedge clk) if (arr_we) mem[arr_addr] <= arr_wdata;
  always @(negedge clk) if (rst_n && arr_we && !write_busy) we_outside++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int mem_diff();
    int d = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] !== expm[i]) d++;
    return d;
  endfunction

  function automatic int exp_addr(input int base, input int i);
    return (base & 'h1F0) | ((base + i) & 'hF);
  endfunction

  task automatic quiet();
    frame_start  = 1'b0;
    byte_valid   = 1'b0;
    sel_release  = 1'b0;
    bit_boundary = 1'b0;
  endtask

  task automatic run_frame(input int addr, input int n, input bit bnd,
                           input bit wl, input bit wpn, input bit same,
                           input bit intrude, input string tag);
    logic [DATA_W-1:0] d [32];
    bit legal;
    int sep;
    int hi, wc, wpos, mis;
    string ftag;
    for (int i = 0; i < 32; i++) d[i] = DATA_W'($urandom);
    legal = bnd && wl && wpn && (n > 0);
    sep   = (same && n > 0) ? n - 1 : n;
    @(negedge clk);
    frame_start = 1'b1;
    start_addr  = ADDR_W'(addr);
    @(negedge clk);
    quiet();
    for (int i = 0; i < sep; i++) begin
      if ($urandom % 3 == 0) @(negedge clk);
      byte_valid = 1'b1;
      byte_data  = d[i];
      @(negedge clk);
      byte_valid = 1'b0;
    end
    sel_release  = 1'b1;
    bit_boundary = bnd;
    wr_en_latch  = wl;
    wr_protect_n = wpn;
    if (same && n > 0) begin
      byte_valid = 1'b1;
      byte_data  = d[n-1];
    end
    @(negedge clk);
    quiet();
    if (legal) for (int i = 0; i < n; i++) expm[exp_addr(addr, i)] = d[i];
    ftag = !bnd || n == 0 ? "R3" : (!wl || !wpn ? "R4" : "R5");
    chk(write_busy == legal, ftag, "busy after release", write_busy, legal);
    if (legal) begin
      hi = 0; wc = 0; wpos = 0; mis = 0;
      while (write_busy && hi < WRC + 5) begin
        hi++;
        if (latch_clr) begin wc++; wpos = hi; end
        if (array_rd_block != write_busy) mis++;
        if (intrude) begin
          quiet();
          if (hi == 2) begin frame_start = 1'b1; start_addr = ADDR_W'(addr ^ 'h0A5); end
          if (hi == 3 || hi == 4) begin byte_valid = 1'b1; byte_data = ~d[hi]; end
          if (hi == 5) begin sel_release = 1'b1; bit_boundary = 1'b1; end
        end
        @(negedge clk);
      end
      quiet();
      chk(hi == WRC, "R5", "busy length", hi, WRC);
      chk(wc == 1, "R7", "latch_clr pulses", wc, 1);
      chk(wpos == WRC, "R7", "latch_clr position", wpos, WRC);
      chk(mis == 0, "R6", "read block mismatches", mis, 0);
      if (intrude) begin
        sel_release = 1'b1; bit_boundary = 1'b1;
        @(negedge clk);
        quiet();
        for (int k = 0; k < 3; k++) begin
          chk(!write_busy, "R9", "no cycle from ignored frame", write_busy, 0);
          @(negedge clk);
        end
      end
    end else begin
      for (int k = 0; k < WRC + 2; k++) begin
        if (write_busy || latch_clr) begin
          chk(0, ftag, "busy without commit", write_busy, 0);
          break;
        end
        @(negedge clk);
      end
    end
    chk(mem_diff() == 0, legal ? tag : ftag, "array mismatches", mem_diff(), 0);
  endtask

  initial begin
    #(TCLK * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]  = '0;
      expm[i] = '0;
    end
    quiet();
    start_addr   = '0;
    byte_data    = '0;
    wr_en_latch  = 1'b1;
    wr_protect_n = 1'b1;
    rst_n        = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!write_busy && !array_rd_block && !latch_clr && !arr_we, "R1",
        "outputs in reset", {write_busy, array_rd_block, latch_clr, arr_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!write_busy && !array_rd_block && !latch_clr && !arr_we, "R1",
        "outputs after reset", {write_busy, array_rd_block, latch_clr, arr_we}, 0);

    run_frame('h1FD, 5,  1, 1, 1, 0, 0, "R2");   // R2 wrap inside page
    run_frame('h040, 20, 1, 1, 1, 0, 0, "R2");   // R2 overwrite after wrap
    run_frame('h100, 1,  1, 1, 1, 0, 0, "R8");   // R8 single byte, rest untouched
    run_frame('h0A3, 4,  0, 1, 1, 0, 0, "R3");   // R3 release off boundary
    run_frame('h0B0, 0,  1, 1, 1, 0, 0, "R3");   // R3 no data byte
    run_frame('h0C7, 3,  1, 0, 1, 0, 0, "R4");   // R4 latch clear
    run_frame('h0D2, 3,  1, 1, 0, 0, 0, "R4");   // R4 protected
    run_frame('h12E, 3,  1, 1, 1, 1, 0, "R10");  // R10 byte on release cycle
    run_frame('h150, 6,  1, 1, 1, 0, 1, "R9");   // R9 frame during busy

    for (int t = 0; t < 25; t++) begin
      run_frame(int'($urandom % DEPTH), int'($urandom % 21),
                ($urandom % 5) != 0, ($urandom % 7) != 0,
                ($urandom % 7) != 0, ($urandom % 3) == 0, 0, "R2");
    end

    // R8 no array strobe outside busy
    chk(we_outside == 0, "R8", "array writes outside busy", we_outside, 0);
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule